// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It writes incoming 32-bit trace words into an on-chip RAM that it treats as a ring. Software controls it through a simple register bus with select, write strobe, address, write data and read data. A write pointer records where the next trace word lands. A read pointer selects the word that software reads out. Both pointers advance by themselves when software uses the RAM data registers, so software can clear the whole RAM or drain it with one access per entry. A sticky flag records that the write pointer has wrapped, which means older trace has been overwritten.

Capture can stop itself in two ways. The first is after a programmable number of words following a trigger pulse. The second is when a flush requested by software is acknowledged. When capture stops for either reason, the block pads the RAM with zero words until the write pointer sits on a four-word frame boundary. It then reports the stopped state. A decoder reading the RAM therefore always finds whole frames. The block drives a flush request to the trace source and ends it on the source's acknowledge.

Top module: `trace_ring_sink`

## Requirements
- R1: The register at address 0x004 reads the RAM depth parameter DEPTH. Writes to it have no effect.
- R2: Control register 0x020 bit 0 enables capture. A trace word is stored at the write pointer, and the pointer advances, only in a cycle where trace_valid is high, capture is enabled and capture has not stopped.
- R3: A bus write to 0x024 stores the write data at the write pointer and advances the pointer modulo DEPTH.
- R4: A bus read of 0x010 returns the RAM word at the read pointer in the same cycle and advances the read pointer modulo DEPTH.
- R5: The read pointer (0x014) and the write pointer (0x018) can be written and read back. A written value is taken modulo DEPTH, and bits above the pointer width read as zero.
- R6: Status register 0x00C bit 0 is set when the write pointer steps from DEPTH-1 to 0. It stays set until software writes the write pointer register.
- R7: Register 0x01C holds a trigger count and reads back as written. When formatter control 0x304 bit 13 is set, the word in the trigger cycle is stored, exactly that many further words are stored after it, and capture then stops.
- R8: Writing 0x304 with bit 6 set raises flush_req. Bit 6 of 0x304 reads 1 while the flush is pending. Both stay high until a cycle with flush_ack, and then both clear.
- R9: When 0x304 bit 12 is set, a flush acknowledge stops capture. When bit 12 is clear, capture continues after the flush.
- R10: After a trigger or flush stop, zero words are written one per cycle until the write pointer is a multiple of 4. Incoming trace is dropped from the stop decision onward.
- R11: Formatter status 0x300 bit 1 reads 1 when control bit 0 is 0 or when a stop has completed. Any write to the control register clears the stopped state and re-arms the trigger.
- R12: Addresses outside the register set read zero. In 0x304, only bits 0, 6, 12 and 13 read back, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| trace_valid | input | 1 | Trace word present |
| trace_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event |
| flush_ack | input | 1 | Source reports the flush done |
| flush_req | output | 1 | Flush requested of the source |

## Verification
The state that is hardest to reach is a stop that lands off a frame boundary. Reaching it needs the trigger or the flush acknowledge to arrive after a word count that is not a multiple of four, with more trace still arriving afterwards. The stimulus therefore places the trigger after three words with a count of five, and also places it on the third word with a count of zero. It acknowledges a flush after two words. In each case the bench checks the zero padding, the final pointer, and that a RAM word beyond the padding keeps its earlier value, which shows the late words were dropped.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam logic [11:0] ADR_DEPTH  = 12'h004;
    localparam logic [11:0] ADR_STAT   = 12'h00C;
    localparam logic [11:0] ADR_RDATA  = 12'h010;
    localparam logic [11:0] ADR_RPTR   = 12'h014;
    localparam logic [11:0] ADR_WPTR   = 12'h018;
    localparam logic [11:0] ADR_TRIG   = 12'h01C;
    localparam logic [11:0] ADR_CTRL   = 12'h020;
    localparam logic [11:0] ADR_WDATA  = 12'h024;
    localparam logic [11:0] ADR_FSTAT  = 12'h300;
    localparam logic [11:0] ADR_FCTRL  = 12'h304;

    localparam int FC_FMT_BIT   = 0;
    localparam int FC_FLUSH_BIT = 6;
    localparam int FC_STFL_BIT  = 12;
    localparam int FC_STTR_BIT  = 13;
    localparam int FS_STOP_BIT  = 1;
    localparam int FRAME_WORDS  = 4;

    typedef struct packed {
        logic stop_on_trig;
        logic stop_on_flush;
        logic fmt_en;
    } fctl_t;

    typedef enum logic [1:0] {
        CAP_RUN  = 2'd0,
        CAP_PAD  = 2'd1,
        CAP_HALT = 2'd2
    } cap_state_e;

    function automatic logic [31:0] ptr_next(input logic [31:0] p, input int unsigned depth);
        return (p == 32'(depth - 1)) ? 32'd0 : p + 32'd1;
    endfunction

endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [PW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trs_capture.sv
module trs_capture
    import trs_pkg::*;
#(
    parameter int FW = $clog2(FRAME_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_en,
    input  logic          ctl_wr,
    input  fctl_t         fctl,
    input  logic          flush_set,
    input  logic          flush_ack,
    input  logic          trig_in,
    input  logic          trace_valid,
    input  logic [31:0]   trig_count,
    input  logic [FW-1:0] wp_low,
    input  logic          bus_ram_wr,
    output logic          cap_we,
    output logic          pad_we,
    output logic          flush_pend,
    output logic          halted
);
    cap_state_e  state;
    logic        trig_seen;
    logic [31:0] remain;
    logic        live, trig_done, flush_stop;

    assign live       = ctl_en && (state == CAP_RUN);
    assign trig_done  = trig_seen && (remain == 32'd0) && fctl.stop_on_trig;
    assign flush_stop = flush_pend && flush_ack && fctl.stop_on_flush && live;
    assign cap_we     = live && trace_valid && !trig_done && !bus_ram_wr;
    assign pad_we     = ctl_en && (state == CAP_PAD) && (wp_low != '0) && !bus_ram_wr;
    assign halted     = (state == CAP_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CAP_RUN;
            trig_seen  <= 1'b0;
            remain     <= '0;
            flush_pend <= 1'b0;
        end else begin
            if (flush_set)
                flush_pend <= 1'b1;
            else if (flush_ack)
                flush_pend <= 1'b0;

            if (ctl_wr) begin
                state     <= CAP_RUN;
                trig_seen <= 1'b0;
            end else begin
                unique case (state)
                    CAP_RUN: begin
                        if (live && trig_in && !trig_seen) begin
                            trig_seen <= 1'b1;
                            remain    <= trig_count;
                        end else if (cap_we && trig_seen && remain != 32'd0) begin
                            remain <= remain - 32'd1;
                        end
                        if (ctl_en && (trig_done || flush_stop))
                            state <= CAP_PAD;
                    end
                    CAP_PAD: begin
                        if (wp_low == '0) state <= CAP_HALT;
                    end
                    default: state <= CAP_HALT;
                endcase
            end
        end
    end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
    import trs_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        trace_valid,
    input  logic [31:0] trace_data,
    input  logic        trig_in,
    input  logic        flush_ack,
    output logic        flush_req
);
    localparam int PW = $clog2(DEPTH);
    localparam int FW = $clog2(FRAME_WORDS);

    logic          wr_acc, rd_acc;
    logic          ctl_en;
    fctl_t         fctl;
    logic [31:0]   trig_count;
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          full_q;
    logic          wp_bus_wr, data_bus_wr, ram_bus_wr, ctl_wr, fctl_wr;
    logic          cap_we, pad_we, halted, flush_pend;
    logic          ram_we;
    logic [31:0]   ram_wdata, ram_rdata;
    logic [31:0]   fctl_word;

    assign wr_acc      = bus_sel && bus_wr;
    assign rd_acc      = bus_sel && !bus_wr;
    assign wp_bus_wr   = wr_acc && (bus_addr == ADR_WPTR);
    assign data_bus_wr = wr_acc && (bus_addr == ADR_WDATA);
    assign ram_bus_wr  = wp_bus_wr || data_bus_wr;
    assign ctl_wr      = wr_acc && (bus_addr == ADR_CTRL);
    assign fctl_wr     = wr_acc && (bus_addr == ADR_FCTRL);

    trs_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .ctl_en      (ctl_en),
        .ctl_wr      (ctl_wr),
        .fctl        (fctl),
        .flush_set   (fctl_wr && bus_wdata[FC_FLUSH_BIT]),
        .flush_ack   (flush_ack),
        .trig_in     (trig_in),
        .trace_valid (trace_valid),
        .trig_count  (trig_count),
        .wp_low      (wr_ptr[FW-1:0]),
        .bus_ram_wr  (ram_bus_wr),
        .cap_we      (cap_we),
        .pad_we      (pad_we),
        .flush_pend  (flush_pend),
        .halted      (halted)
    );

    assign flush_req = flush_pend;
    assign ram_we    = data_bus_wr || cap_we || pad_we;
    assign ram_wdata = data_bus_wr ? bus_wdata : (cap_we ? trace_data : 32'd0);

    trs_ram #(.DEPTH(DEPTH), .PW(PW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (wr_ptr),
        .wdata (ram_wdata),
        .raddr (rd_ptr),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en     <= 1'b0;
            fctl       <= '0;
            trig_count <= '0;
            rd_ptr     <= '0;
            wr_ptr     <= '0;
            full_q     <= 1'b0;
        end else begin
            if (ctl_wr) ctl_en <= bus_wdata[0];
            if (fctl_wr) begin
                fctl.fmt_en        <= bus_wdata[FC_FMT_BIT];
                fctl.stop_on_flush <= bus_wdata[FC_STFL_BIT];
                fctl.stop_on_trig  <= bus_wdata[FC_STTR_BIT];
            end
            if (wr_acc && bus_addr == ADR_TRIG) trig_count <= bus_wdata;

            if (wr_acc && bus_addr == ADR_RPTR)
                rd_ptr <= PW'(bus_wdata % DEPTH);
            else if (rd_acc && bus_addr == ADR_RDATA)
                rd_ptr <= PW'(ptr_next(32'(rd_ptr), DEPTH));

            if (wp_bus_wr) begin
                wr_ptr <= PW'(bus_wdata % DEPTH);
                full_q <= 1'b0;
            end else if (ram_we) begin
                wr_ptr <= PW'(ptr_next(32'(wr_ptr), DEPTH));
                if (32'(wr_ptr) == 32'(DEPTH - 1)) full_q <= 1'b1;
            end
        end
    end

    always_comb begin
        fctl_word               = '0;
        fctl_word[FC_FMT_BIT]   = fctl.fmt_en;
        fctl_word[FC_FLUSH_BIT] = flush_pend;
        fctl_word[FC_STFL_BIT]  = fctl.stop_on_flush;
        fctl_word[FC_STTR_BIT]  = fctl.stop_on_trig;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (bus_addr)
                ADR_DEPTH: bus_rdata = 32'(DEPTH);
                ADR_STAT:  bus_rdata = {31'd0, full_q};
                ADR_RDATA: bus_rdata = ram_rdata;
                ADR_RPTR:  bus_rdata = 32'(rd_ptr);
                ADR_WPTR:  bus_rdata = 32'(wr_ptr);
                ADR_TRIG:  bus_rdata = trig_count;
                ADR_CTRL:  bus_rdata = {31'd0, ctl_en};
                ADR_FSTAT: bus_rdata = 32'((!ctl_en || halted) ? (1 << FS_STOP_BIT) : 0);
                ADR_FCTRL: bus_rdata = fctl_word;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/trs_checker.sv
module trs_checker
    import trs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] wr_ptr,
    input logic          full_q,
    input logic          cap_we,
    input logic          pad_we,
    input logic          halted,
    input logic          wp_bus_wr,
    input logic          ram_bus_wr,
    input logic          flush_req,
    input logic          flush_ack
);
    assert_capture_step_R2: assert property (@(posedge clk) disable iff (rst)
        cap_we |=> 32'(wr_ptr) == ptr_next(32'($past(wr_ptr)), DEPTH));

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        full_q && !wp_bus_wr |=> full_q);

    assert_flush_ends_on_ack_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_req) |-> $past(flush_ack));

    assert_pad_step_R10: assert property (@(posedge clk) disable iff (rst)
        pad_we |=> 32'(wr_ptr) == ptr_next(32'($past(wr_ptr)), DEPTH));

    assert_halt_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) && !$past(ram_bus_wr) |-> wr_ptr[1:0] == 2'd0);

    assert_no_write_halted_R11: assert property (@(posedge clk) disable iff (rst)
        halted |-> !cap_we && !pad_we);
endmodule

bind trace_ring_sink trs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_ptr     (wr_ptr),
    .full_q     (full_q),
    .cap_we     (cap_we),
    .pad_we     (pad_we),
    .halted     (halted),
    .wp_bus_wr  (wp_bus_wr),
    .ram_bus_wr (ram_bus_wr),
    .flush_req  (flush_req),
    .flush_ack  (flush_ack)
);

// File: tb/trace_ring_sink_tb.sv
module trace_ring_sink_tb;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trace_valid = 1'b0, trig_in = 1'b0, flush_ack = 1'b0;
    logic [31:0] trace_data = '0;
    logic        flush_req;

    int          n_chk = 0, n_err = 0;
    bit          finished = 1'b0;
    logic [31:0] model [D];
    logic [31:0] rv;

    always #5 clk = ~clk;

    trace_ring_sink #(.DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trace_valid(trace_valid), .trace_data(trace_data), .trig_in(trig_in),
        .flush_ack(flush_ack), .flush_req(flush_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input logic t);
        @(negedge clk);
        trace_valid = 1'b1; trace_data = d; trig_in = t;
        @(posedge clk); #1;
        trace_valid = 1'b0; trig_in = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        flush_ack = 1'b1;
        @(posedge clk); #1;
        flush_ack = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // reset state
        brd(12'h004, rv); chk("R1 depth", rv, D);
        brd(12'h00C, rv); chk("R6 full after reset", rv, 0);
        brd(12'h300, rv); chk("R11 stopped while disabled", rv, 32'h2);
        brd(12'h018, rv); chk("R5 wptr reset", rv, 0);
        bwr(12'h004, 32'h5);
        brd(12'h004, rv); chk("R1 depth write ignored", rv, D);
        brd(12'h008, rv); chk("R12 unmapped 0x008", rv, 0);
        brd(12'h100, rv); chk("R12 unmapped 0x100", rv, 0);

        // pointer access, modulo depth
        bwr(12'h014, 32'hFFFF_FFF3);
        brd(12'h014, rv); chk("R5 rptr modulo", rv, 32'h3);
        bwr(12'h018, 32'h25);
        brd(12'h018, rv); chk("R5 wptr modulo", rv, 32'h5);

        // software fill of every entry
        bwr(12'h018, 0);
        for (int i = 0; i < D; i++) begin
            model[i] = 32'hA000_0000 + 32'(i * 7);
            bwr(12'h024, model[i]);
            if (i == D - 2) begin
                brd(12'h00C, rv); chk("R6 no full before wrap", rv, 0);
            end
        end
        brd(12'h018, rv); chk("R3 wptr wrapped", rv, 0);
        brd(12'h00C, rv); chk("R6 full after wrap", rv, 1);

        // software drain of every entry
        bwr(12'h014, 0);
        for (int i = 0; i < D; i++) begin
            brd(12'h010, rv); chk($sformatf("R4 read word %0d", i), rv, model[i]);
        end
        brd(12'h014, rv); chk("R4 rptr wrapped", rv, 0);
        bwr(12'h014, D - 2);
        brd(12'h010, rv); chk("R4 read D-2", rv, model[D-2]);
        brd(12'h010, rv); chk("R4 read D-1", rv, model[D-1]);
        brd(12'h010, rv); chk("R4 read wraps to 0", rv, model[0]);
        bwr(12'h018, 0);
        brd(12'h00C, rv); chk("R6 full cleared by wptr write", rv, 0);

        // capture gating
        push(32'h1111, 1'b0); push(32'h2222, 1'b0);
        brd(12'h018, rv); chk("R2 no capture while disabled", rv, 0);
        bwr(12'h020, 1);
        brd(12'h300, rv); chk("R11 running", rv, 0);
        for (int i = 0; i < 5; i++) begin
            model[i] = 32'hC000_0000 + 32'(i);
            push(model[i], 1'b0);
            wait_cyc(i % 3);
        end
        brd(12'h018, rv); chk("R2 wptr after 5 words", rv, 5);
        bwr(12'h014, 0);
        for (int i = 0; i < 5; i++) begin
            brd(12'h010, rv); chk($sformatf("R2 captured word %0d", i), rv, model[i]);
        end
        bwr(12'h020, 0);
        push(32'h3333, 1'b0);
        brd(12'h018, rv); chk("R2 disable stops capture", rv, 5);

        // trigger with count 5, stop off frame boundary
        bwr(12'h01C, 5);
        brd(12'h01C, rv); chk("R7 trigger count readback", rv, 5);
        bwr(12'h304, 32'hFFFF_FFBF);
        brd(12'h304, rv); chk("R12 fctrl unused bits zero", rv, 32'h3001);
        bwr(12'h304, 32'h2001);
        bwr(12'h018, 0);
        bwr(12'h020, 1);
        for (int i = 0; i < 12; i++) begin
            if (i < 9) model[i] = 32'hB000_0000 + 32'(i);
            push(32'hB000_0000 + 32'(i), i == 3);
        end
        wait_cyc(6);
        brd(12'h018, rv); chk("R7 R10 wptr after trigger stop", rv, 12);
        brd(12'h300, rv); chk("R11 stopped after trigger", rv, 32'h2);
        bwr(12'h014, 0);
        for (int i = 0; i < 9; i++) begin
            brd(12'h010, rv); chk($sformatf("R7 stored word %0d", i), rv, model[i]);
        end
        for (int i = 9; i < 12; i++) begin
            brd(12'h010, rv); chk($sformatf("R10 pad word %0d", i), rv, 0);
        end
        brd(12'h010, rv); chk("R10 late trace dropped", rv, 32'hA000_0000 + 32'(12 * 7));

        // trigger with count 0
        bwr(12'h01C, 0);
        bwr(12'h018, 0);
        bwr(12'h020, 1);
        brd(12'h300, rv); chk("R11 control write rearms", rv, 0);
        for (int i = 0; i < 5; i++) push(32'hD000_0000 + 32'(i), i == 2);
        wait_cyc(4);
        brd(12'h018, rv); chk("R7 count 0 stops after trigger word", rv, 4);
        bwr(12'h014, 2);
        brd(12'h010, rv); chk("R7 trigger word stored", rv, 32'hD000_0002);
        brd(12'h010, rv); chk("R10 pad after count 0", rv, 0);

        // trigger without stop enable
        bwr(12'h304, 32'h1);
        bwr(12'h018, 0);
        bwr(12'h020, 1);
        push(32'hE0, 1'b1); push(32'hE1, 1'b0); push(32'hE2, 1'b0);
        wait_cyc(3);
        brd(12'h018, rv); chk("R7 no stop without bit 13", rv, 3);
        brd(12'h300, rv); chk("R11 still running", rv, 0);

        // flush with stop
        bwr(12'h018, 0);
        bwr(12'h020, 1);
        bwr(12'h304, 32'h1041);
        chk("R8 flush_req raised", flush_req, 1);
        brd(12'h304, rv); chk("R8 flush bit pending", rv, 32'h1041);
        push(32'hF0, 1'b0); push(32'hF1, 1'b0);
        wait_cyc(4);
        chk("R8 flush_req held without ack", flush_req, 1);
        ack_pulse();
        chk("R8 flush_req cleared by ack", flush_req, 0);
        brd(12'h304, rv); chk("R8 flush bit cleared", rv, 32'h1001);
        wait_cyc(4);
        push(32'hF9, 1'b0);
        brd(12'h018, rv); chk("R9 R10 wptr after flush stop", rv, 4);
        brd(12'h300, rv); chk("R9 stopped after flush", rv, 32'h2);
        bwr(12'h014, 1);
        brd(12'h010, rv); chk("R9 last word before flush", rv, 32'hF1);
        brd(12'h010, rv); chk("R10 flush pad word 2", rv, 0);
        brd(12'h010, rv); chk("R10 flush pad word 3", rv, 0);

        // flush without stop
        bwr(12'h018, 0);
        bwr(12'h020, 1);
        bwr(12'h304, 32'h41);
        ack_pulse();
        wait_cyc(3);
        brd(12'h300, rv); chk("R9 no stop without bit 12", rv, 0);
        push(32'h77, 1'b0);
        brd(12'h018, rv); chk("R9 capture continues", rv, 1);

        finish_run();
    end
endmodule